// File: doc/BRIEF.md
# Peer Setup Message Parser

This block sits between a byte link from a coordinating server and the rest of a node that shares a memory window with other nodes. The server sends 64-bit control words one byte at a time, least significant byte first. Each word may carry a sideband flag that says a notification handle came with it. The parser assembles the words and runs a fixed opening exchange: a protocol version word comes first, then the node's own identifier. After that it accepts peer notices in any order until a grant word (all ones) says the shared window is available. At that point setup is complete.

It keeps a table with one entry per peer. The entry holds how many notification vectors that peer has registered. A notice that carries a handle registers the next vector for that peer: the vector number is the current count. A notice without a handle drops all of that peer's vectors. The table tracks how many slots are in use. It starts with room for 16 peers and grows when a higher index is named, up to a hard limit set by a parameter.

The parser also settles the node's master role from a mode input and the identifier it was given. Errors during setup stop the parser for good. Errors after setup only raise a one-cycle flag, and parsing continues.

Top module: `peer_setup_parser`

## Requirements
- R1: A word is processed only once its eighth byte has been accepted. Byte k of the word fills bits [8k+7:8k], so bytes arrive least significant first. The handle flag is taken together with the eighth byte.
- R2: The first word must equal the parameter PROTO_VER (default 0) and carry no handle. Otherwise the parser enters a permanent failed state: setup_fail_o goes high, byte_ready_o goes low and err_o pulses.
- R3: The second word must carry no handle and hold a value from 0 to 65535. That value appears on own_id_o. Any other second word causes the failed state.
- R4: master_mode_i selects the master role: 2'b00 is automatic, 2'b01 is forced off and 2'b10 is forced on. In automatic mode master_o is 1 only when the identifier is 0. In forced-on mode a nonzero identifier causes the failed state, and an identifier of 0 gives master_o = 1. In forced-off mode master_o stays 0.
- R5: After the identifier, words are processed until the value 64'hFFFF_FFFF_FFFF_FFFF arrives. That word raises setup_done_o, which then stays high.
- R6: A word whose signed value is below -1 or above 65535 is an error. Before setup_done_o it causes the failed state. After setup_done_o it only pulses err_o.
- R7: A grant word received after setup_done_o pulses err_o.
- R8: A peer word with a handle raises that peer's count by one. If the count already equals NUM_VECTORS (default 4), err_o pulses and the count stays unchanged.
- R9: A peer word without a handle clears that peer's count to 0. If the index equals own_id_o, err_o pulses and the count stays unchanged.
- R10: slots_o starts at 16 after reset. A peer word with an index at or above slots_o sets slots_o to the index plus one. A peer word with an index at or above MAX_PEERS (default 32) pulses err_o and changes neither slots_o nor any count.
- R11: After setup_done_o, errors do not stop the parser. Later words still update the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_i | input | 8 | Incoming message byte |
| byte_valid_i | input | 1 | byte_i holds a byte |
| byte_ready_o | output | 1 | Parser accepts a byte (low once failed) |
| handle_i | input | 1 | Handle-present flag, sampled with the eighth byte |
| master_mode_i | input | 2 | 00 automatic, 01 forced off, 10 forced on |
| rd_idx_i | input | 5 | Peer table read index |
| rd_count_o | output | 3 | Registered vector count of the peer at rd_idx_i |
| slots_o | output | 6 | Number of peer slots in use |
| own_id_o | output | 16 | Node identifier taken from the second word |
| master_o | output | 1 | Master role |
| setup_done_o | output | 1 | Grant received, setup complete |
| setup_fail_o | output | 1 | Setup failed; parser stopped |
| err_o | output | 1 | One-cycle pulse for each rejected word |

## Verification
A wrong byte slot in the assembler shows up at once. The identifier and the slot count come out byte-swapped, and this is visible two cycles after the eighth byte. A wrong handshake state shows one word later. The identifier is not taken, a grant does not raise setup_done_o, or a valid word leaves the parser failed with byte_ready_o low. A wrong count in a peer entry appears on rd_count_o right after the update. It also appears later as a missing or extra err_o when the count reaches its limit, so the limit is driven on purpose, and so are the own-identifier disconnect and the out-of-table index.

// File: rtl/peer_setup_pkg.sv
package peer_setup_pkg;
  typedef enum logic [2:0] {
    ST_VER  = 3'd0,
    ST_ID   = 3'd1,
    ST_RUN  = 3'd2,
    ST_DONE = 3'd3,
    ST_FAIL = 3'd4
  } setup_st_e;

  typedef enum logic [1:0] {
    MM_AUTO = 2'b00,
    MM_OFF  = 2'b01,
    MM_ON   = 2'b10
  } master_mode_e;

  localparam int unsigned MSG_BYTES = 8;
  localparam int unsigned ID_W      = 16;
endpackage

// File: rtl/psp_byte_asm.sv
module psp_byte_asm #(
  parameter int unsigned MSG_BYTES = 8,
  localparam int unsigned CNT_W = $clog2(MSG_BYTES),
  localparam int unsigned MSG_W = 8 * MSG_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       byte_i,
  input  logic             take_i,
  input  logic             handle_i,
  output logic [MSG_W-1:0] msg_o,
  output logic             msg_v_o,
  output logic             handle_o
);
  logic [CNT_W-1:0] idx_q;
  logic [MSG_W-9:0] part_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      part_q   <= '0;
      msg_o    <= '0;
      msg_v_o  <= 1'b0;
      handle_o <= 1'b0;
    end else begin
      msg_v_o <= 1'b0;
      if (take_i) begin
        if (idx_q == CNT_W'(MSG_BYTES - 1)) begin
          msg_o    <= {byte_i, part_q};
          msg_v_o  <= 1'b1;
          handle_o <= handle_i;
          idx_q    <= '0;
        end else begin
          part_q[idx_q*8 +: 8] <= byte_i;
          idx_q                <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/psp_peer_table.sv
module psp_peer_table #(
  parameter int unsigned MAX_PEERS   = 32,
  parameter int unsigned INIT_PEERS  = 16,
  parameter int unsigned NUM_VECTORS = 4,
  localparam int unsigned PEER_W = $clog2(MAX_PEERS),
  localparam int unsigned CNT_W  = $clog2(NUM_VECTORS + 1),
  localparam int unsigned SLOT_W = PEER_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PEER_W-1:0] idx_i,
  input  logic              grow_i,
  input  logic              inc_i,
  input  logic              clr_i,
  input  logic [PEER_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0]  cnt_at_idx_o,
  output logic [CNT_W-1:0]  rd_cnt_o,
  output logic [SLOT_W-1:0] slots_o
);
  logic [CNT_W-1:0] cnt_all [MAX_PEERS];

  for (genvar g = 0; g < MAX_PEERS; g++) begin : g_ent
    logic [CNT_W-1:0] c_q;
    logic             hit;
    assign hit = (idx_i == PEER_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           c_q <= '0;
      else if (inc_i && hit) c_q <= c_q + 1'b1;
      else if (clr_i && hit) c_q <= '0;
    end
    assign cnt_all[g] = c_q;
  end

  assign cnt_at_idx_o = cnt_all[idx_i];
  assign rd_cnt_o     = cnt_all[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slots_o <= SLOT_W'(INIT_PEERS);
    else if (grow_i && ({1'b0, idx_i} >= slots_o))
      slots_o <= {1'b0, idx_i} + SLOT_W'(1);
  end
endmodule

// File: rtl/peer_setup_parser.sv
module peer_setup_parser
  import peer_setup_pkg::*;
#(
  parameter logic [63:0] PROTO_VER   = 64'd0,
  parameter int unsigned NUM_VECTORS = 4,
  parameter int unsigned MAX_PEERS   = 32,
  parameter int unsigned INIT_PEERS  = 16,
  localparam int unsigned PEER_W = $clog2(MAX_PEERS),
  localparam int unsigned CNT_W  = $clog2(NUM_VECTORS + 1),
  localparam int unsigned SLOT_W = PEER_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        byte_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  input  logic              handle_i,
  input  logic [1:0]        master_mode_i,
  input  logic [PEER_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0]  rd_count_o,
  output logic [SLOT_W-1:0] slots_o,
  output logic [ID_W-1:0]   own_id_o,
  output logic              master_o,
  output logic              setup_done_o,
  output logic              setup_fail_o,
  output logic              err_o
);
  localparam logic [ID_W-1:0] MAXP = ID_W'(MAX_PEERS);

  setup_st_e          st_q, st_d;
  logic [63:0]        msg;
  logic signed [63:0] msg_s;
  logic               msg_v, hdl;
  logic [ID_W-1:0]    own_d;
  logic               mst_d, err_d;
  logic               grow, inc, clr;
  logic [CNT_W-1:0]   cnt_at;
  logic               is_grant, is_bad, in_tbl, evt_err;

  assign byte_ready_o = (st_q != ST_FAIL);

  psp_byte_asm #(.MSG_BYTES(MSG_BYTES)) u_asm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .byte_i   (byte_i),
    .take_i   (byte_valid_i && byte_ready_o),
    .handle_i (handle_i),
    .msg_o    (msg),
    .msg_v_o  (msg_v),
    .handle_o (hdl)
  );

  psp_peer_table #(
    .MAX_PEERS  (MAX_PEERS),
    .INIT_PEERS (INIT_PEERS),
    .NUM_VECTORS(NUM_VECTORS)
  ) u_tbl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (msg[PEER_W-1:0]),
    .grow_i      (grow),
    .inc_i       (inc),
    .clr_i       (clr),
    .rd_idx_i    (rd_idx_i),
    .cnt_at_idx_o(cnt_at),
    .rd_cnt_o    (rd_count_o),
    .slots_o     (slots_o)
  );

  assign msg_s    = $signed(msg);
  assign is_grant = (msg == '1);
  assign is_bad   = (msg_s < -64'sd1) || (msg_s > 64'sd65535);
  assign in_tbl   = (msg[ID_W-1:0] < MAXP);

  always_comb begin
    st_d    = st_q;
    own_d   = own_id_o;
    mst_d   = master_o;
    err_d   = 1'b0;
    grow    = 1'b0;
    inc     = 1'b0;
    clr     = 1'b0;
    evt_err = 1'b0;
    if (msg_v) begin
      unique case (st_q)
        ST_VER: begin
          if (hdl || msg != PROTO_VER) evt_err = 1'b1;
          else                         st_d = ST_ID;
        end
        ST_ID: begin
          if (hdl || msg_s < 64'sd0 || msg_s > 64'sd65535) begin
            evt_err = 1'b1;
          end else if (master_mode_i == MM_ON && msg[ID_W-1:0] != '0) begin
            evt_err = 1'b1;
          end else begin
            own_d = msg[ID_W-1:0];
            mst_d = (master_mode_i == MM_ON) ||
                    (master_mode_i == MM_AUTO && msg[ID_W-1:0] == '0);
            st_d  = ST_RUN;
          end
        end
        ST_RUN, ST_DONE: begin
          if (is_bad) evt_err = 1'b1;
          else if (is_grant) begin
            if (st_q == ST_DONE) evt_err = 1'b1;
            else                 st_d = ST_DONE;
          end else if (!in_tbl) evt_err = 1'b1;
          else begin
            grow = 1'b1;
            if (hdl) begin
              if (cnt_at == CNT_W'(NUM_VECTORS)) evt_err = 1'b1;
              else                               inc = 1'b1;
            end else begin
              if (msg[ID_W-1:0] == own_id_o) evt_err = 1'b1;
              else                           clr = 1'b1;
            end
          end
        end
        default: ;
      endcase
      if (evt_err) begin
        err_d = 1'b1;
        if (st_q != ST_DONE) st_d = ST_FAIL;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_VER;
      own_id_o <= '0;
      master_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      st_q     <= st_d;
      own_id_o <= own_d;
      master_o <= mst_d;
      err_o    <= err_d;
    end
  end

  assign setup_done_o = (st_q == ST_DONE);
  assign setup_fail_o = (st_q == ST_FAIL);
endmodule

// File: rtl/psp_checker.sv
module psp_checker #(
  parameter int unsigned NUM_VECTORS = 4,
  parameter int unsigned MAX_PEERS   = 32,
  parameter int unsigned CNT_W       = 3,
  parameter int unsigned SLOT_W      = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_ready_o,
  input logic [CNT_W-1:0]  rd_count_o,
  input logic [SLOT_W-1:0] slots_o,
  input logic [15:0]       own_id_o,
  input logic              master_o,
  input logic              setup_done_o,
  input logic              setup_fail_o
);
  p_fail_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_fail_o |=> setup_fail_o);
  p_ready_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_fail_o |-> !byte_ready_o);
  p_master_id_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_o |-> own_id_o == 16'd0);
  p_done_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_done_o |=> setup_done_o);
  p_done_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(setup_done_o && setup_fail_o));
  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_count_o <= CNT_W'(NUM_VECTORS));
  p_slots_mono_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !setup_fail_o |=> slots_o >= $past(slots_o));
  p_slots_max_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slots_o <= SLOT_W'(MAX_PEERS));
endmodule

bind peer_setup_parser psp_checker #(
  .NUM_VECTORS(NUM_VECTORS),
  .MAX_PEERS  (MAX_PEERS),
  .CNT_W      (CNT_W),
  .SLOT_W     (SLOT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .byte_ready_o(byte_ready_o),
  .rd_count_o  (rd_count_o),
  .slots_o     (slots_o),
  .own_id_o    (own_id_o),
  .master_o    (master_o),
  .setup_done_o(setup_done_o),
  .setup_fail_o(setup_fail_o)
);

// File: tb/peer_setup_parser_tb_top.sv
module peer_setup_parser_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        byte_valid_i = 1'b0;
  logic        byte_ready_o;
  logic        handle_i = 1'b0;
  logic [1:0]  master_mode_i = 2'b00;
  logic [4:0]  rd_idx_i = '0;
  logic [2:0]  rd_count_o;
  logic [5:0]  slots_o;
  logic [15:0] own_id_o;
  logic        master_o, setup_done_o, setup_fail_o, err_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit ended   = 1'b0;

  always #5 clk_i = ~clk_i;

  peer_setup_parser dut_i (.*);

  // msg[80:17] hdl[16] err[15] idx[14:10] cnt[9:7] slots[6:1] done[0]
  localparam logic [80:0] VEC [16] = '{
    {64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 5'd0,  3'd0, 6'd16, 1'b1},
    {64'd5,                   1'b1, 1'b0, 5'd5,  3'd1, 6'd16, 1'b1},
    {64'd5,                   1'b1, 1'b0, 5'd5,  3'd2, 6'd16, 1'b1},
    {64'd5,                   1'b1, 1'b0, 5'd5,  3'd3, 6'd16, 1'b1},
    {64'd5,                   1'b1, 1'b0, 5'd5,  3'd4, 6'd16, 1'b1},
    {64'd5,                   1'b1, 1'b1, 5'd5,  3'd4, 6'd16, 1'b1},
    {64'd5,                   1'b0, 1'b0, 5'd5,  3'd0, 6'd16, 1'b1},
    {64'd3,                   1'b1, 1'b0, 5'd3,  3'd1, 6'd16, 1'b1},
    {64'd3,                   1'b0, 1'b1, 5'd3,  3'd1, 6'd16, 1'b1},
    {64'd20,                  1'b1, 1'b0, 5'd20, 3'd1, 6'd21, 1'b1},
    {64'd40,                  1'b1, 1'b1, 5'd20, 3'd1, 6'd21, 1'b1},
    {64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 5'd0,  3'd0, 6'd21, 1'b1},
    {64'hFFFF_FFFF_FFFF_FFFB, 1'b0, 1'b1, 5'd0,  3'd0, 6'd21, 1'b1},
    {64'h0000_0000_0001_0000, 1'b1, 1'b1, 5'd0,  3'd0, 6'd21, 1'b1},
    {64'd7,                   1'b1, 1'b0, 5'd7,  3'd1, 6'd21, 1'b1},
    {64'd0,                   1'b0, 1'b0, 5'd0,  3'd0, 6'd21, 1'b1}
  };

  function automatic string tag_of(int i);
    case (i)
      0:             return "R5";
      1, 2, 3, 4, 5: return "R8";
      6, 7, 8, 15:   return "R9";
      9, 10:         return "R10";
      11:            return "R7";
      12, 13:        return "R6";
      default:       return "R11";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    byte_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic send_msg(logic [63:0] m, logic h);
    for (int b = 0; b < 8; b++) begin
      byte_i       = m[8*b +: 8];
      byte_valid_i = 1'b1;
      handle_i     = h;
      @(negedge clk_i);
    end
    byte_valid_i = 1'b0;
    handle_i     = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic handshake(logic [63:0] id, logic [1:0] mode);
    master_mode_i = mode;
    send_msg(64'd0, 1'b0);
    send_msg(id, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!ended) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // reset state
    chk("R2",  "ready after reset", 64'(byte_ready_o), 64'd1);
    chk("R2",  "fail after reset", 64'(setup_fail_o), 64'd0);
    chk("R5",  "done after reset", 64'(setup_done_o), 64'd0);
    chk("R10", "slots after reset", 64'(slots_o), 64'd16);
    chk("R8",  "count after reset", 64'(rd_count_o), 64'd0);
    chk("R6",  "err after reset", 64'(err_o), 64'd0);

    // main table walk: auto mode, id 3
    handshake(64'd3, 2'b00);
    chk("R3", "own id", 64'(own_id_o), 64'd3);
    chk("R4", "auto master nonzero id", 64'(master_o), 64'd0);
    chk("R5", "not done before grant", 64'(setup_done_o), 64'd0);
    for (int i = 0; i < 16; i++) begin
      send_msg(VEC[i][80:17], VEC[i][16]);
      chk(tag_of(i), $sformatf("entry %0d err", i), 64'(err_o), 64'(VEC[i][15]));
      rd_idx_i = VEC[i][14:10];
      #1;
      chk(tag_of(i), $sformatf("entry %0d count", i), 64'(rd_count_o), 64'(VEC[i][9:7]));
      chk(tag_of(i), $sformatf("entry %0d slots", i), 64'(slots_o), 64'(VEC[i][6:1]));
      chk(tag_of(i), $sformatf("entry %0d done", i), 64'(setup_done_o), 64'(VEC[i][0]));
    end
    chk("R11", "not failed after errors", 64'(setup_fail_o), 64'd0);
    @(negedge clk_i);
    chk("R6", "err is one cycle", 64'(err_o), 64'd0);

    // R1: byte order for id and peer index
    do_reset();
    handshake(64'h0000_0000_0000_0102, 2'b00);
    chk("R1", "id byte order", 64'(own_id_o), 64'h0102);
    send_msg(64'h11, 1'b1);
    chk("R1", "peer index byte order", 64'(slots_o), 64'd18);

    // R2: bad version / version with handle
    do_reset();
    send_msg(64'd1, 1'b0);
    chk("R2", "bad version fail", 64'(setup_fail_o), 64'd1);
    chk("R2", "bad version err", 64'(err_o), 64'd1);
    chk("R2", "ready low", 64'(byte_ready_o), 64'd0);
    send_msg(64'd0, 1'b0);
    send_msg(64'd2, 1'b0);
    chk("R2", "stays failed", 64'(setup_fail_o), 64'd1);
    chk("R2", "id ignored when failed", 64'(own_id_o), 64'd0);
    do_reset();
    send_msg(64'd0, 1'b1);
    chk("R2", "version with handle", 64'(setup_fail_o), 64'd1);

    // R3: id with handle, id out of range
    do_reset();
    send_msg(64'd0, 1'b0);
    send_msg(64'd4, 1'b1);
    chk("R3", "id with handle", 64'(setup_fail_o), 64'd1);
    do_reset();
    handshake(64'h1_0000, 2'b00);
    chk("R3", "id 65536", 64'(setup_fail_o), 64'd1);
    do_reset();
    handshake(64'hFFFF_FFFF_FFFF_FFFF, 2'b00);
    chk("R3", "id -1", 64'(setup_fail_o), 64'd1);

    // R4: master modes
    do_reset();
    handshake(64'd2, 2'b10);
    chk("R4", "forced on nonzero id fails", 64'(setup_fail_o), 64'd1);
    do_reset();
    handshake(64'd0, 2'b10);
    chk("R4", "forced on id 0 master", 64'(master_o), 64'd1);
    chk("R4", "forced on id 0 ok", 64'(setup_fail_o), 64'd0);
    do_reset();
    handshake(64'd0, 2'b01);
    chk("R4", "forced off master", 64'(master_o), 64'd0);
    do_reset();
    handshake(64'd0, 2'b00);
    chk("R4", "auto id 0 master", 64'(master_o), 64'd1);

    // R6: invalid word before grant stops setup
    do_reset();
    handshake(64'd3, 2'b00);
    send_msg(64'hFFFF_FFFF_FFFF_FFFE, 1'b0);
    chk("R6", "invalid before done fails", 64'(setup_fail_o), 64'd1);
    chk("R6", "invalid before done err", 64'(err_o), 64'd1);

    // R5: peer words before the grant, then grant
    do_reset();
    handshake(64'd3, 2'b00);
    send_msg(64'd9, 1'b1);
    chk("R5", "still running", 64'(setup_done_o), 64'd0);
    send_msg(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    chk("R5", "grant completes", 64'(setup_done_o), 64'd1);
    rd_idx_i = 5'd9;
    #1;
    chk("R8", "pre-grant connect kept", 64'(rd_count_o), 64'd1);

    ended = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule